// File: doc/BRIEF.md
# Two-Bank SRAM Power and Availability Controller

This block governs power and access for a 128KB on-chip SRAM organised as two 64KB banks. From the current operating mode and two configuration bits for the second bank, it decides each cycle which bank is powered. It drives one power-enable line per bank and reports which bank is ECC/parity protected. Bank 0 is the protected bank and stays alive down to standby. Bank 1 is unprotected. Software can switch it off, and it can also be made to drop automatically while the chip is in stop mode.

Bus requests carry a byte offset into the 128KB space. The block steers each request to its bank with zero wait states. A request that hits an unpowered bank gets a single-cycle error instead of a ready, and the array is never enabled. Each bank also has a contents-valid flag. The flag drops whenever the bank is unpowered and comes back on the first write accepted after power returns.

Top module: `sram_pwr_ctrl`

## Requirements
- R1: Bit 16 of addr_i selects the bank (0 selects bank 0, 1 selects bank 1). A request asserts only the ready bit of the selected bank.
- R2: The mode encoding is run=0, sleep=1, stop=2, standby=3, shutdown=4, and codes 5 to 7 behave as shutdown. pwr_en_o[0] is high after a clock edge at which the mode was 0 to 3, and low after an edge at which it was shutdown.
- R3: pwr_en_o[1] is high after an edge only if b1_off_i was 0 and the mode was run, sleep or stop. Otherwise it is low.
- R4: If b1_stop_off_i is 1 at an edge where the mode is stop, pwr_en_o[1] is low after that edge. With the bit clear, bank 1 stays powered in stop.
- R5: prot_o is constant 2'b01: bank 0 is protected and bank 1 is not.
- R6: A request to a bank whose pwr_en_o bit is low raises err_o in the same cycle. It raises no ready bit, and err_o stays high only while such a request is present.
- R7: A request to a powered bank raises that bank's ready bit combinationally in the same cycle, with no wait state.
- R8: valid_o[b] goes low after any edge at which pwr_en_o[b] was low. It goes high after an edge where a write (req_i=1, we_i=1) was accepted by a powered bank b. Reads never set it.
- R9: After reset, pwr_en_o=2'b11 (run mode, bank 1 enabled), valid_o=2'b00, and err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode code |
| b1_off_i | input | 1 | Software disable for bank 1 |
| b1_stop_off_i | input | 1 | Power bank 1 down while in stop |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Request is a write |
| addr_i | input | 17 | Byte offset into the 128KB space |
| pwr_en_o | output | 2 | Per-bank power enable |
| ready_o | output | 2 | Per-bank zero-wait access ready / array enable |
| err_o | output | 1 | Access to unpowered bank |
| valid_o | output | 2 | Per-bank contents-valid flag |
| prot_o | output | 2 | Per-bank ECC/parity protection flag |

## Verification
The assertions assume that mode_i and the two configuration bits are stable around the rising edge. They also assume req_i and we_i are never unknown after reset, so each edge sees one defined mode and one defined request. The bench changes every input on the falling edge and samples outputs just before the next rising edge or just after the falling-edge update, which keeps it inside those assumptions. It uses the undefined mode codes only deliberately, to check that they behave as shutdown.

// File: rtl/sram_pwr_pkg.sv
package sram_pwr_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_AW   = 16;           // 64KB per bank
  localparam int unsigned ADDR_W    = BANK_AW + 1;  // 128KB total

  typedef enum logic [2:0] {
    MODE_RUN      = 3'd0,
    MODE_SLEEP    = 3'd1,
    MODE_STOP     = 3'd2,
    MODE_STANDBY  = 3'd3,
    MODE_SHUTDOWN = 3'd4
  } op_mode_e;
endpackage

// File: rtl/sram_pwr_policy.sv
module sram_pwr_policy
  import sram_pwr_pkg::*;
(
  input  logic [2:0]           mode_i,
  input  logic                 b1_off_i,
  input  logic                 b1_stop_off_i,
  output logic [NUM_BANKS-1:0] pwr_next_o
);
  logic alive_deep, alive_light, is_stop;

  always_comb begin
    is_stop     = (mode_i == MODE_STOP);
    alive_light = (mode_i == MODE_RUN) || (mode_i == MODE_SLEEP) || is_stop;
    alive_deep  = alive_light || (mode_i == MODE_STANDBY);
    pwr_next_o[0] = alive_deep;
    pwr_next_o[1] = alive_light && !b1_off_i && !(is_stop && b1_stop_off_i);
  end
endmodule

// File: rtl/sram_bank_decode.sv
module sram_bank_decode
  import sram_pwr_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] sel_oh_o
);
  always_comb begin
    sel_oh_o = '0;
    sel_oh_o[addr_i[BANK_AW]] = 1'b1;
  end
endmodule

// File: rtl/sram_bank_state.sv
module sram_bank_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_next_i,
  input  logic wr_hit_i,
  output logic pwr_q_o,
  output logic valid_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q_o   <= 1'b1;
      valid_q_o <= 1'b0;
    end else begin
      pwr_q_o <= pwr_next_i;
      if (!pwr_q_o)      valid_q_o <= 1'b0;
      else if (wr_hit_i) valid_q_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_pwr_ctrl.sv
module sram_pwr_ctrl
  import sram_pwr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           mode_i,
  input  logic                 b1_off_i,
  input  logic                 b1_stop_off_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] pwr_en_o,
  output logic [NUM_BANKS-1:0] ready_o,
  output logic                 err_o,
  output logic [NUM_BANKS-1:0] valid_o,
  output logic [NUM_BANKS-1:0] prot_o
);
  localparam logic [NUM_BANKS-1:0] PROT_MAP = 2'b01;

  logic [NUM_BANKS-1:0] pwr_next, sel_oh, hit;

  sram_pwr_policy u_policy (
    .mode_i        (mode_i),
    .b1_off_i      (b1_off_i),
    .b1_stop_off_i (b1_stop_off_i),
    .pwr_next_o    (pwr_next)
  );

  sram_bank_decode u_decode (
    .addr_i   (addr_i),
    .sel_oh_o (sel_oh)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit[b] = req_i && sel_oh[b] && pwr_en_o[b];
    sram_bank_state u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwr_next_i (pwr_next[b]),
      .wr_hit_i   (hit[b] && we_i),
      .pwr_q_o    (pwr_en_o[b]),
      .valid_q_o  (valid_o[b])
    );
  end

  assign ready_o = hit;
  assign err_o   = req_i && ~|(sel_oh & pwr_en_o);
  assign prot_o  = PROT_MAP;
endmodule

// File: rtl/sram_pwr_ctrl_chk.sv
module sram_pwr_ctrl_chk
  import sram_pwr_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           mode_i,
  input logic                 b1_off_i,
  input logic                 b1_stop_off_i,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [NUM_BANKS-1:0] pwr_en_o,
  input logic [NUM_BANKS-1:0] ready_o,
  input logic                 err_o,
  input logic [NUM_BANKS-1:0] valid_o,
  input logic [NUM_BANKS-1:0] prot_o
);
  logic sel_b;
  assign sel_b = addr_i[BANK_AW];

  assert_ready_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ready_o) && !(ready_o[~sel_b]));

  assert_b0_alive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i <= MODE_STANDBY) |=> pwr_en_o[0]);

  assert_b0_dead_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= MODE_SHUTDOWN) |=> !pwr_en_o[0]);

  assert_b1_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b1_off_i || mode_i >= MODE_STANDBY) |=> !pwr_en_o[1]);

  assert_b1_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP && b1_stop_off_i) |=> !pwr_en_o[1]);

  assert_prot_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o == 2'b01);

  assert_err_dead_bank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pwr_en_o[sel_b]) |-> (err_o && ready_o == '0));

  assert_zero_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && pwr_en_o[sel_b]) |-> (ready_o[sel_b] && !err_o));

  assert_valid_b0_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o[0] |=> !valid_o[0]);

  assert_valid_b1_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o[1] |=> !valid_o[1]);

  assert_read_no_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o[0] && !(req_i && we_i)) |=> !valid_o[0]);
endmodule

bind sram_pwr_ctrl sram_pwr_ctrl_chk u_chk (.*);

// File: tb/sram_pwr_ctrl_bench.sv
module sram_pwr_ctrl_bench;
  import sram_pwr_pkg::*;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic b1_off_i = 1'b0, b1_stop_off_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [1:0] pwr_en_o, ready_o, valid_o, prot_o;
  logic err_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  sram_pwr_ctrl u_sram_pwr_ctrl (.*);

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // drive at falling edge, settle, sample
  task automatic drv(logic r, logic w, logic bk);
    @(negedge clk_i);
    req_i = r; we_i = w; addr_i = {bk, 16'h1234};
    #1;
  endtask

  task automatic step();  // one rising edge, then sample point
    @(posedge clk_i); #1;
  endtask

  task automatic set_cfg(logic [2:0] m, logic off, logic soff);
    @(negedge clk_i);
    mode_i = m; b1_off_i = off; b1_stop_off_i = soff;
    req_i = 1'b0; we_i = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R9 pwr", 8'(pwr_en_o), 8'h3);
    chk("R9 valid", 8'(valid_o), 8'h0);
    chk("R9 err", 8'(err_o), 8'h0);
    chk("R5 prot", 8'(prot_o), 8'h1);
  endtask

  task automatic t_access();
    drv(1, 0, 0); chk("R1 R7 bank0 ready", 8'(ready_o), 8'h1);
    drv(1, 0, 1); chk("R1 R7 bank1 ready", 8'(ready_o), 8'h2);
    chk("R7 no err", 8'(err_o), 8'h0);
    drv(0, 0, 1); chk("R1 idle", 8'(ready_o), 8'h0);
  endtask

  task automatic t_modes();
    set_cfg(MODE_SLEEP, 0, 0);   chk("R2 R3 sleep", 8'(pwr_en_o), 8'h3);
    set_cfg(MODE_STOP, 0, 0);    chk("R4 stop keep", 8'(pwr_en_o), 8'h3);
    set_cfg(MODE_STOP, 0, 1);    chk("R4 stop drop", 8'(pwr_en_o), 8'h1);
    set_cfg(MODE_STANDBY, 0, 0); chk("R2 R3 standby", 8'(pwr_en_o), 8'h1);
    set_cfg(MODE_SHUTDOWN, 0, 0); chk("R2 shutdown", 8'(pwr_en_o), 8'h0);
    set_cfg(3'd6, 0, 0);         chk("R2 undef code", 8'(pwr_en_o), 8'h0);
    set_cfg(MODE_RUN, 1, 0);     chk("R3 sw off", 8'(pwr_en_o), 8'h1);
    set_cfg(MODE_RUN, 0, 1);     chk("R4 run ignores", 8'(pwr_en_o), 8'h3);
  endtask

  task automatic t_error();
    set_cfg(MODE_RUN, 1, 0);
    drv(1, 1, 1);
    chk("R6 err", 8'(err_o), 8'h1);
    chk("R6 no ready", 8'(ready_o), 8'h0);
    step();
    chk("R6 array untouched", 8'(valid_o[1]), 8'h0);
    drv(0, 0, 1); chk("R6 err clears", 8'(err_o), 8'h0);
    drv(1, 0, 0); chk("R6 live bank ok", 8'(err_o), 8'h0);
    drv(0, 0, 0);
  endtask

  task automatic t_valid();
    set_cfg(MODE_RUN, 0, 0);
    drv(1, 0, 1); step(); chk("R8 read no set", 8'(valid_o), 8'h0);
    drv(1, 1, 1); step(); chk("R8 write sets b1", 8'(valid_o), 8'h2);
    drv(1, 1, 0); step(); chk("R8 write sets b0", 8'(valid_o), 8'h3);
    drv(0, 0, 0);
    set_cfg(MODE_STOP, 0, 1);  // pwr drops at this edge
    step(); chk("R8 b1 lost", 8'(valid_o), 8'h1);
    set_cfg(MODE_RUN, 0, 0);
    step(); chk("R8 stays clear on power up", 8'(valid_o), 8'h1);
    drv(1, 1, 1); step(); chk("R8 rewrite", 8'(valid_o), 8'h3);
    drv(0, 0, 0);
    set_cfg(MODE_SHUTDOWN, 0, 0);
    step(); chk("R8 both lost", 8'(valid_o), 8'h0);
    set_cfg(MODE_RUN, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    t_reset();
    t_access();
    t_modes();
    t_error();
    t_valid();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule